// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This peripheral counts ticks from one of two clock-enable inputs and works either as a system watchdog or as a periodic interval timer. In watchdog mode the counter must be restarted by software before it reaches its terminal count. If it is not restarted, the block raises a one-cycle reset request and returns its control register to its power-up value. In interval mode the counter wraps at the terminal count and keeps running. Each wrap sets an interrupt flag, which can be routed to an interrupt request.

Software reaches the block through a 16-bit control register and two single-bit registers. The control register is guarded by a key byte in its upper half. The single-bit registers are the interrupt flag, which software can write directly, and the interrupt enable. A global interrupt enable and an interrupt acknowledge come from the surrounding interrupt logic. The acknowledge clears the flag once the interval interrupt has been serviced.

Top module: `wdt_dual_timer`

## Requirements
- R1: Control bits [1:0] choose how many qualifying ticks pass from a zero count to expiry: code 00 gives 32768, 01 gives 8192, 10 gives 512 and 11 gives 64.
- R2: When control bit 2 is 1, only `aux_tick` advances the counter. When it is 0, only `sub_tick` advances it. The unselected tick has no effect.
- R3: After reset, `ctl_rdata` reads 16'h6900 (watchdog mode, `sub_tick` source, 32768 period, not held), and `flag_o`, `ien_o`, `irq_o` and `rst_req_o` are 0.
- R4: When control bit 4 is 1 (interval mode), expiry wraps the counter to zero, counting continues and `rst_req_o` stays 0.
- R5: When control bit 4 is 0 (watchdog mode), expiry drives `rst_req_o` high for exactly the following cycle and returns the control register to its reset value.
- R6: Expiry sets `flag_o` in either mode. A write with `flag_we` loads `flag_wdata` into the flag.
- R7: `irq_o` is 1 exactly when interval mode is selected and `flag_o`, `ien_o` and `gie` are all 1.
- R8: In interval mode, `irq_ack` clears the flag on the next edge. If expiry occurs in the same cycle, the flag stays set.
- R9: When control bit 7 (hold) is 1, the counter does not advance and no expiry occurs.
- R10: A control write takes effect only when `ctl_wdata[15:8]` is 8'h5A. Any other key leaves the written value unused, pulses `rst_req_o` for one cycle, restores the reset control value and zeroes the counter. Reads always show 8'h69 in bits [15:8].
- R11: A valid write with bit 3 set zeroes the counter, and bit 3 always reads 0. A valid write that changes bit 4 or bits [1:0] also zeroes the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aux_tick | input | 1 | Slow auxiliary count enable |
| sub_tick | input | 1 | Fast subsystem count enable |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data, key in [15:8] |
| ctl_rdata | output | 16 | Control register read value |
| flag_we | input | 1 | Interrupt flag write strobe |
| flag_wdata | input | 1 | Interrupt flag write value |
| flag_o | output | 1 | Interrupt flag |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 1 | Interrupt enable write value |
| ien_o | output | 1 | Interrupt enable |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt serviced acknowledge |
| irq_o | output | 1 | Interval interrupt request |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The interval expiry and the interrupt acknowledge can fall in the same cycle, and they pull the flag in opposite directions. The bench sets up this collision by running the counter to one tick short of the limit with the flag already set. It then drives the final tick and `irq_ack` on the same edge. The flag must read 1 afterwards, and a later acknowledge on its own must clear it. Random tick densities, with noise on the unselected tick, check that expiry lands on exactly the tick count that the select code implies.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [7:0] WDT_KEY    = 8'h5A;
    localparam logic [7:0] WDT_RD_TAG = 8'h69;
    localparam int HOLD_BIT = 7;
    localparam int MODE_BIT = 4;
    localparam int CLR_BIT  = 3;
    localparam int SRC_BIT  = 2;

    typedef struct packed {
        logic       hold;
        logic       mode;   // 1: interval, 0: watchdog
        logic       src;    // 1: aux tick, 0: subsystem tick
        logic [1:0] sel;
    } wdt_ctl_t;

    localparam wdt_ctl_t CTL_RST = '{hold: 1'b0, mode: 1'b0, src: 1'b0, sel: 2'b00};

    typedef struct packed {
        wdt_ctl_t ctl;
        logic     flag;
        logic     ien;
        logic     rst_req;
    } wdt_state_t;
endpackage

// File: rtl/wdt_limit_dec.sv
module wdt_limit_dec #(
    parameter int CNT_W  = 16,
    parameter int LOG_P0 = 15,
    parameter int LOG_P1 = 13,
    parameter int LOG_P2 = 9,
    parameter int LOG_P3 = 6
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] limit_m1
);
    localparam logic [CNT_W-1:0] LM0 = CNT_W'((64'd1 << LOG_P0) - 64'd1);
    localparam logic [CNT_W-1:0] LM1 = CNT_W'((64'd1 << LOG_P1) - 64'd1);
    localparam logic [CNT_W-1:0] LM2 = CNT_W'((64'd1 << LOG_P2) - 64'd1);
    localparam logic [CNT_W-1:0] LM3 = CNT_W'((64'd1 << LOG_P3) - 64'd1);

    always_comb begin
        unique case (sel)
            2'b00:   limit_m1 = LM0;
            2'b01:   limit_m1 = LM1;
            2'b10:   limit_m1 = LM2;
            default: limit_m1 = LM3;
        endcase
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit_m1,
    output logic             expire,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = tick && !hold && !restart && (cnt_q == limit_m1);
        cnt_d  = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (tick && !hold)
            cnt_d = expire ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit_m1);

    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !restart |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_dual_timer.sv
module wdt_dual_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int LOG_P0 = 15,
    parameter int LOG_P1 = 13,
    parameter int LOG_P2 = 9,
    parameter int LOG_P3 = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        aux_tick,
    input  logic        sub_tick,
    input  logic        ctl_we,
    input  logic [15:0] ctl_wdata,
    output logic [15:0] ctl_rdata,
    input  logic        flag_we,
    input  logic        flag_wdata,
    output logic        flag_o,
    input  logic        ien_we,
    input  logic        ien_wdata,
    output logic        ien_o,
    input  logic        gie,
    input  logic        irq_ack,
    output logic        irq_o,
    output logic        rst_req_o
);
    wdt_state_t       s_d, s_q;
    wdt_ctl_t         new_ctl;
    logic             key_ok, good_wr, bad_wr, restart, tick, expire;
    logic [CNT_W-1:0] limit_m1, cnt;
    logic             unused_bits;

    assign unused_bits = ^{ctl_wdata[6:5], cnt};

    wdt_limit_dec #(
        .CNT_W(CNT_W), .LOG_P0(LOG_P0), .LOG_P1(LOG_P1),
        .LOG_P2(LOG_P2), .LOG_P3(LOG_P3)
    ) u_dec (
        .sel      (s_q.ctl.sel),
        .limit_m1 (limit_m1)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hold     (s_q.ctl.hold),
        .restart  (restart),
        .limit_m1 (limit_m1),
        .expire   (expire),
        .cnt      (cnt)
    );

    always_comb begin
        key_ok  = (ctl_wdata[15:8] == WDT_KEY);
        good_wr = ctl_we && key_ok;
        bad_wr  = ctl_we && !key_ok;
        new_ctl = '{hold: ctl_wdata[HOLD_BIT], mode: ctl_wdata[MODE_BIT],
                    src: ctl_wdata[SRC_BIT], sel: ctl_wdata[1:0]};
        restart = bad_wr ||
                  (good_wr && (ctl_wdata[CLR_BIT] ||
                               (new_ctl.mode != s_q.ctl.mode) ||
                               (new_ctl.sel  != s_q.ctl.sel)));
        tick    = s_q.ctl.src ? aux_tick : sub_tick;

        s_d         = s_q;
        s_d.rst_req = 1'b0;

        // control register: valid write, then key failure or watchdog bite override
        if (good_wr) s_d.ctl = new_ctl;
        if (bad_wr || (expire && !s_q.ctl.mode)) begin
            s_d.ctl     = CTL_RST;
            s_d.rst_req = 1'b1;
        end

        if (ien_we) s_d.ien = ien_wdata;

        // flag priority: expiry > software write > acknowledge
        if (irq_ack && s_q.ctl.mode) s_d.flag = 1'b0;
        if (flag_we)                 s_d.flag = flag_wdata;
        if (expire)                  s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ctl: CTL_RST, flag: 1'b0, ien: 1'b0, rst_req: 1'b0};
        else        s_q <= s_d;
    end

    assign ctl_rdata = {WDT_RD_TAG, s_q.ctl.hold, 2'b00, s_q.ctl.mode,
                        1'b0, s_q.ctl.src, s_q.ctl.sel};
    assign flag_o    = s_q.flag;
    assign ien_o     = s_q.ien;
    assign irq_o     = s_q.ctl.mode && s_q.flag && s_q.ien && gie;
    assign rst_req_o = s_q.rst_req;

    // R5
    wd_bite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !s_q.ctl.mode |=> rst_req_o && (ctl_rdata == 16'h6900));

    // R4
    interval_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire && s_q.ctl.mode && !ctl_we |=> !rst_req_o);

    // R6
    flag_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_o);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && s_q.ctl.mode && !expire && !flag_we |=> !flag_o);

    // R10
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we && (ctl_wdata[15:8] != 8'h5A) |=> rst_req_o && (ctl_rdata[7:0] == 8'h00));
endmodule

// File: tb/wdt_dual_timer_test.sv
module wdt_dual_timer_test;
    logic        clk = 1'b0;
    logic        rst_n, aux_tick, sub_tick, ctl_we, flag_we, flag_wdata;
    logic        ien_we, ien_wdata, gie, irq_ack;
    logic [15:0] ctl_wdata, ctl_rdata;
    logic        flag_o, ien_o, irq_o, rst_req_o;
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    wdt_dual_timer uut (
        .clk(clk), .rst_n(rst_n), .aux_tick(aux_tick), .sub_tick(sub_tick),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .flag_we(flag_we), .flag_wdata(flag_wdata), .flag_o(flag_o),
        .ien_we(ien_we), .ien_wdata(ien_wdata), .ien_o(ien_o),
        .gie(gie), .irq_ack(irq_ack), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    function automatic int lim_of(input logic [1:0] s);
        case (s)
            2'b00:   return 32768;
            2'b01:   return 8192;
            2'b10:   return 512;
            default: return 64;
        endcase
    endfunction

    function automatic logic [15:0] rd_of(input logic [15:0] w);
        return {8'h69, w[7], 2'b00, w[4], 1'b0, w[2], w[1:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input bit use_aux, input logic v);
        if (use_aux) begin aux_tick = v; sub_tick = 1'($urandom % 2); end
        else         begin sub_tick = v; aux_tick = 1'($urandom % 2); end
    endtask

    task automatic ticks(input int n, input bit use_aux, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps) while ($urandom % 4 == 0) begin @(negedge clk); drive(use_aux, 1'b0); end
            @(negedge clk); drive(use_aux, 1'b1);
        end
        @(negedge clk); sub_tick = 1'b0; aux_tick = 1'b0; #1;
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk); sub_tick = 1'b0; aux_tick = 1'b0; ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0; #1;
    endtask

    task automatic flag_wr(input logic v);
        @(negedge clk); flag_we = 1'b1; flag_wdata = v;
        @(negedge clk); flag_we = 1'b0; #1;
    endtask

    task automatic ien_wr(input logic v);
        @(negedge clk); ien_we = 1'b1; ien_wdata = v;
        @(negedge clk); ien_we = 1'b0; #1;
    endtask

    task automatic ack_once();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0; #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 190000);
            $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [1:0]  sel;
        bit          src;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; aux_tick = 1'b0; sub_tick = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
        flag_we = 1'b0; flag_wdata = 1'b0; ien_we = 1'b0; ien_wdata = 1'b0;
        gie = 1'b0; irq_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; #1;

        // R3 reset state
        chk("R3 ctl", ctl_rdata, 16'h6900);
        chk("R3 flag", flag_o, 0);
        chk("R3 ien", ien_o, 0);
        chk("R3 irq", irq_o, 0);
        chk("R3 rst_req", rst_req_o, 0);

        // R1 / R5 default 32768 watchdog period
        wr(16'h5A08);
        chk("R11 clear reads 0", ctl_rdata, 16'h6900);
        ticks(32767, 1'b0, 1'b0);
        chk("R1 no bite before 32768", rst_req_o, 0);
        ticks(1, 1'b0, 1'b0);
        chk("R1 bite at 32768", rst_req_o, 1);
        chk("R5 ctl restored", ctl_rdata, 16'h6900);
        chk("R6 flag on bite", flag_o, 1);
        @(negedge clk); #1;
        chk("R5 one-cycle pulse", rst_req_o, 0);
        flag_wr(1'b0);
        chk("R6 flag write", flag_o, 0);

        // R4 interval mode, 64 ticks
        wr(16'h5A1B);
        chk("R11 readback", ctl_rdata, 16'h6913);
        ticks(63, 1'b0, 1'b1);
        chk("R4 flag before limit", flag_o, 0);
        ticks(1, 1'b0, 1'b0);
        chk("R1 flag at 64", flag_o, 1);
        chk("R4 no reset request", rst_req_o, 0);
        flag_wr(1'b0);
        ticks(64, 1'b0, 1'b1);
        chk("R4 wrap and repeat", flag_o, 1);

        // R7 interrupt gating
        ien_wr(1'b1);
        gie = 1'b1; #1;
        chk("R7 irq all set", irq_o, 1);
        gie = 1'b0; #1;
        chk("R7 irq gie low", irq_o, 0);
        gie = 1'b1; ien_wr(1'b0);
        chk("R7 irq ien low", irq_o, 0);
        ien_wr(1'b1);

        // R8 acknowledge
        ack_once();
        chk("R8 ack clears flag", flag_o, 0);
        chk("R7 irq drops", irq_o, 0);

        // R8 expiry and acknowledge on the same edge
        flag_wr(1'b1);
        ticks(63, 1'b0, 1'b0);
        @(negedge clk); sub_tick = 1'b1; irq_ack = 1'b1;
        @(negedge clk); sub_tick = 1'b0; irq_ack = 1'b0; #1;
        chk("R8 expiry beats ack", flag_o, 1);
        ack_once();
        chk("R8 later ack", flag_o, 0);

        // R2 source select
        wr(16'h5A1F);
        repeat (100) begin @(negedge clk); sub_tick = 1'b1; aux_tick = 1'b0; end
        @(negedge clk); sub_tick = 1'b0; #1;
        chk("R2 sub tick ignored", flag_o, 0);
        ticks(63, 1'b1, 1'b1);
        chk("R2 aux before limit", flag_o, 0);
        ticks(1, 1'b1, 1'b0);
        chk("R2 aux expiry", flag_o, 1);

        // R9 hold
        flag_wr(1'b0);
        wr(16'h5A9B);
        chk("R9 readback", ctl_rdata, 16'h6993);
        ticks(200, 1'b0, 1'b0);
        chk("R9 held", flag_o, 0);
        wr(16'h5A13);
        ticks(63, 1'b0, 1'b0);
        chk("R9 release count", flag_o, 0);
        ticks(1, 1'b0, 1'b0);
        chk("R9 release expiry", flag_o, 1);

        // R11 clear restarts
        flag_wr(1'b0);
        ticks(40, 1'b0, 1'b0);
        wr(16'h5A1B);
        ticks(63, 1'b0, 1'b0);
        chk("R11 clear restart", flag_o, 0);
        ticks(1, 1'b0, 1'b0);
        chk("R11 clear expiry", flag_o, 1);

        // R11 period change restarts
        flag_wr(1'b0);
        ticks(30, 1'b0, 1'b0);
        wr(16'h5A12);
        ticks(511, 1'b0, 1'b0);
        chk("R11 sel change restart", flag_o, 0);
        ticks(1, 1'b0, 1'b0);
        chk("R1 flag at 512", flag_o, 1);

        // R10 bad key
        wr(16'h1213);
        chk("R10 bad key reset request", rst_req_o, 1);
        chk("R10 write ignored", ctl_rdata, 16'h6900);
        @(negedge clk); #1;
        chk("R10 pulse ends", rst_req_o, 0);

        // R5 short watchdog period
        wr(16'h5A0B);
        chk("R5 readback", ctl_rdata, 16'h6903);
        ticks(63, 1'b0, 1'b1);
        chk("R5 no bite early", rst_req_o, 0);
        ticks(1, 1'b0, 1'b0);
        chk("R5 bite", rst_req_o, 1);
        chk("R5 ctl restored short", ctl_rdata, 16'h6900);

        // R1 / R2 randomized periods and sources
        for (int it = 0; it < 6; it++) begin
            sel = 2'(1 + $urandom % 3);
            src = 1'($urandom % 2);
            v = 16'h5A18 | {13'd0, src, sel};
            wr(v);
            chk("R11 random readback", ctl_rdata, rd_of(v));
            flag_wr(1'b0);
            ticks(lim_of(sel) - 1, src, 1'b1);
            chk("R1 random before limit", flag_o, 0);
            ticks(1, src, 1'b0);
            chk("R1 random at limit", flag_o, 1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule